// File: doc/BRIEF.md
# Bidirectional I/O Port with Read-Modify-Write Bit Operations

This block is a six-pin general-purpose I/O port for a small microcontroller core. Each pin has an output data latch and a direction bit. The core side issues one operation per instruction cycle: a full write of the latch, a read of the pins, a bit-set or bit-clear chosen by a 3-bit index, or a load of the direction bits from the working register. Each instruction cycle is split into four phases, Q1 to Q4. The core supplies the phase number on `qPhase` and holds the operation steady for the whole cycle.

Reads always return the live pin levels, never the latch. A bit-set or bit-clear works the same way as a software read-modify-write. It samples all pins in Q2, changes one bit, and writes the whole six-bit result into the latch in Q4. A pin that is an input at that moment therefore has its latch replaced by whatever level is on the pad. If that pin later becomes an output, it drives the captured level.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset every direction bit is 1, so `padOe` = 0. `padOut` equals the parameter `LATCH_RST` (default 0), and `rData` = 0.
- R2: A read operation (code 2) captures `padIn` into the read register on the clock edge that ends Q2 (`qPhase` = 1). `rData` carries that value in bits 5:0 with bits 7:6 at 0. It holds the value until the next Q2 capture made by a read, bit-set or bit-clear.
- R3: A write operation (code 1) loads `wData[5:0]` into the output latch on the edge that ends Q4 (`qPhase` = 3). `wData[7:6]` is ignored. `padOut` always shows the latch.
- R4: A direction load (code 5) copies `wData[5:0]` into the direction bits on the Q4 edge. A direction bit of 1 makes the pin an input (`padOe` bit 0); a 0 makes it an output (`padOe` bit 1).
- R5: Bit-set (code 3) and bit-clear (code 4) sample `padIn` on the Q2 edge. On the Q4 edge they load the latch with that sample, with bit `bitIdx` forced to 1 (set) or 0 (clear).
- R6: After a bit operation, the latch bit of every input pin holds the level sampled from its pad. When such a pin is later turned into an output, it drives that sampled level.
- R7: A bit operation with `bitIdx` 6 or 7 leaves the latch unchanged. Its Q2 sample still updates `rData`.
- R8: Operations act only in their own phase. An operation not present in Q2 captures nothing, and one not present in Q4 loads nothing. Codes 0, 6 and 7 change no state.
- R9: A write followed at once by a read returns the newly written level on output pins, because the read samples in Q2 of the next instruction cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per phase |
| rst_n | input | 1 | Active-low asynchronous reset |
| qPhase | input | 2 | Current phase: 0=Q1, 1=Q2, 2=Q3, 3=Q4 |
| opCode | input | 3 | Operation: 0 none, 1 write, 2 read, 3 bit-set, 4 bit-clear, 5 direction load |
| bitIdx | input | 3 | Bit index for bit-set and bit-clear |
| wData | input | 8 | Working-register data for write and direction load |
| rData | output | 8 | Read data: sampled pins in bits 5:0, zeros above |
| padIn | input | 6 | Levels seen at the pads |
| padOut | output | 6 | Output latch driven towards the pads |
| padOe | output | 6 | Per-pin output enable, 1 = drive |

## Verification
Latch and direction results are due on the clock edge that closes Q4 of the issuing instruction. The bench drives the four phases on falling edges, waits for the Q4 rising edge, and samples one nanosecond later. Read results are due on the Q2 edge and stay stable until the next capture, so they are checked at the same point after Q4. The pad model feeds `padOut` back to `padIn` on every enabled pin and external pulls elsewhere, so the expected read value of each instruction depends only on the state left by the previous one.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_BSET  = 3'd3,
    OP_BCLR  = 3'd4,
    OP_DIRLD = 3'd5
  } portOp_e;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } portPhase_e;

  // Strobes from the phase decoder to the datapath
  typedef struct packed {
    logic capPins;   // sample pads into read register
    logic wrLatch;   // load latch from working data
    logic rmwLatch;  // load latch from modified pin sample
    logic rmwSet;    // 1 = set selected bit, 0 = clear it
    logic loadDir;   // load direction bits
  } portStrobes_t;

endpackage

// File: rtl/gpio_rmw_ctrl.sv
module gpio_rmw_ctrl
  import gpio_rmw_pkg::*;
#(
  parameter int PORT_W = 6,
  parameter int IDX_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         qPhase,
  input  logic [2:0]         opCode,
  input  logic [IDX_W-1:0]   bitIdx,
  output portStrobes_t       strobes
);

  logic isBitOp;
  logic idxInPort;
  logic inQ2;
  logic inQ4;

  always_comb begin
    inQ2      = (qPhase == PH_Q2);
    inQ4      = (qPhase == PH_Q4);
    isBitOp   = (opCode == OP_BSET) || (opCode == OP_BCLR);
    idxInPort = (bitIdx < IDX_W'(PORT_W));

    strobes          = '0;
    strobes.capPins  = inQ2 && ((opCode == OP_READ) || isBitOp);
    strobes.wrLatch  = inQ4 && (opCode == OP_WRITE);
    strobes.rmwLatch = inQ4 && isBitOp && idxInPort;
    strobes.rmwSet   = (opCode == OP_BSET);
    strobes.loadDir  = inQ4 && (opCode == OP_DIRLD);
  end

  // R8: at most one state-changing strobe per phase
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.capPins, strobes.wrLatch, strobes.rmwLatch, strobes.loadDir}));

  // R2: pin capture only ever happens in Q2
  p_cap_in_q2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capPins |-> (qPhase == PH_Q2));

  // R7: an index beyond the port never reaches the latch
  p_idx_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bitIdx >= IDX_W'(PORT_W)) |-> !strobes.rmwLatch);

  // R8: latch and direction loads only in Q4
  p_load_in_q4_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrLatch || strobes.rmwLatch || strobes.loadDir) |-> (qPhase == PH_Q4));

endmodule

// File: rtl/gpio_rmw_datapath.sv
module gpio_rmw_datapath
  import gpio_rmw_pkg::*;
#(
  parameter int                PORT_W    = 6,
  parameter int                DATA_W    = 8,
  parameter int                IDX_W     = 3,
  parameter logic [PORT_W-1:0] LATCH_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  portStrobes_t       strobes,
  input  logic [IDX_W-1:0]   bitIdx,
  input  logic [DATA_W-1:0]  wData,
  input  logic [PORT_W-1:0]  padIn,
  output logic [PORT_W-1:0]  padOut,
  output logic [PORT_W-1:0]  padOe,
  output logic [DATA_W-1:0]  rData
);

  localparam int PAD_W = DATA_W - PORT_W;

  logic [PORT_W-1:0] latchQ;
  logic [PORT_W-1:0] dirQ;
  logic [PORT_W-1:0] sampleQ;
  logic [PORT_W-1:0] latchNext;
  logic [PORT_W-1:0] selMask;

  // Per-pin next-latch selection
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic selHit;
    assign selHit       = (bitIdx == IDX_W'(i));
    assign selMask[i]   = selHit;
    always_comb begin
      if (strobes.wrLatch)
        latchNext[i] = wData[i];
      else if (strobes.rmwLatch)
        latchNext[i] = selHit ? strobes.rmwSet : sampleQ[i];
      else
        latchNext[i] = latchQ[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchQ  <= LATCH_RST;
      dirQ    <= '1;
      sampleQ <= '0;
    end else begin
      latchQ <= latchNext;
      if (strobes.loadDir) dirQ    <= wData[PORT_W-1:0];
      if (strobes.capPins) sampleQ <= padIn;
    end
  end

  assign padOut = latchQ;
  assign padOe  = ~dirQ;
  assign rData  = {{PAD_W{1'b0}}, sampleQ};

  // R2: read data holds between captures
  p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.capPins |=> $stable(rData));

  // R8: latch holds when no load strobe
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.wrLatch || strobes.rmwLatch) |=> $stable(padOut));

  // R4: direction load takes the working data
  p_dir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadDir |=> (padOe == ~$past(wData[PORT_W-1:0])));

  // R5: selected bit lands with the set/clear value
  p_rmw_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rmwLatch |=>
      ((padOut & $past(selMask)) == ($past(strobes.rmwSet) ? $past(selMask) : '0)));

  // R6: all other bits come from the pin sample
  p_rmw_others_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rmwLatch |=>
      ((padOut & ~$past(selMask)) == ($past(rData[PORT_W-1:0]) & ~$past(selMask))));

  // R3: full write takes the working data
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrLatch |=> (padOut == $past(wData[PORT_W-1:0])));

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_rmw_pkg::*;
#(
  parameter int                PORT_W    = 6,
  parameter int                DATA_W    = 8,
  parameter logic [PORT_W-1:0] LATCH_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        qPhase,
  input  logic [2:0]        opCode,
  input  logic [2:0]        bitIdx,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe
);

  localparam int IDX_W = 3;

  portStrobes_t strobes;

  gpio_rmw_ctrl #(
    .PORT_W (PORT_W),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .qPhase  (qPhase),
    .opCode  (opCode),
    .bitIdx  (bitIdx),
    .strobes (strobes)
  );

  gpio_rmw_datapath #(
    .PORT_W    (PORT_W),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .LATCH_RST (LATCH_RST)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .bitIdx  (bitIdx),
    .wData   (wData),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .rData   (rData)
  );

endmodule

// File: tb/gpio_rmw_port_bench.sv
`timescale 1ns/1ps
module gpio_rmw_port_bench;
  import gpio_rmw_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] qPhase = 2'd0;
  logic [2:0] opCode = OP_NOP;
  logic [2:0] bitIdx = 3'd0;
  logic [7:0] wData = 8'h00;
  logic [7:0] rData;
  logic [5:0] padIn;
  logic [5:0] padOut;
  logic [5:0] padOe;
  logic [5:0] extPull = 6'h3F;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Pads: driven pins read back their own output, others see the pull
  assign padIn = (padOe & padOut) | (~padOe & extPull);

  gpio_rmw_port u_gpio_rmw_port (
    .clk    (clk),
    .rst_n  (rst_n),
    .qPhase (qPhase),
    .opCode (opCode),
    .bitIdx (bitIdx),
    .wData  (wData),
    .rData  (rData),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe)
  );

  // {op, idx, wData, extPull, expOut, expOe, expRd}
  localparam int NVEC = 13;
  localparam logic [39:0] VECS [NVEC] = '{
    {OP_DIRLD, 3'd0, 8'h38, 6'h3F, 6'h00, 6'h07, 8'h00},
    {OP_WRITE, 3'd0, 8'h05, 6'h3F, 6'h05, 6'h07, 8'h00},
    {OP_READ,  3'd0, 8'h00, 6'h3F, 6'h05, 6'h07, 8'h3D},
    {OP_READ,  3'd0, 8'h00, 6'h00, 6'h05, 6'h07, 8'h05},
    {OP_WRITE, 3'd0, 8'hC2, 6'h00, 6'h02, 6'h07, 8'h05},
    {OP_BSET,  3'd0, 8'h00, 6'h28, 6'h2B, 6'h07, 8'h2A},
    {OP_BCLR,  3'd1, 8'h00, 6'h00, 6'h01, 6'h07, 8'h03},
    {OP_BSET,  3'd6, 8'h00, 6'h3F, 6'h01, 6'h07, 8'h39},
    {OP_BCLR,  3'd7, 8'h00, 6'h00, 6'h01, 6'h07, 8'h01},
    {OP_DIRLD, 3'd0, 8'hFF, 6'h00, 6'h01, 6'h00, 8'h01},
    {OP_READ,  3'd0, 8'h00, 6'h15, 6'h01, 6'h00, 8'h15},
    {OP_DIRLD, 3'd0, 8'h00, 6'h15, 6'h01, 6'h3F, 8'h15},
    {OP_READ,  3'd0, 8'h00, 6'h3F, 6'h01, 6'h3F, 8'h01}
  };

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One instruction cycle; mask bit p enables the operation in phase p
  task automatic runInstr(input logic [2:0] op, input logic [2:0] idx,
                          input logic [7:0] w, input logic [3:0] mask);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      qPhase = 2'(p);
      opCode = mask[p] ? op : OP_NOP;
      bitIdx = idx;
      wData  = w;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n  = 1'b0;
    opCode = OP_NOP;
    qPhase = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    string tag;
    logic [39:0] v;

    // R1: reset state
    doReset();
    check("R1", "padOe", {2'b0, padOe}, 8'h00);
    check("R1", "padOut", {2'b0, padOut}, 8'h00);
    check("R1", "rData", rData, 8'h00);

    // Vector table
    for (int n = 0; n < NVEC; n++) begin
      v = VECS[n];
      case (v[39:37])
        OP_WRITE: tag = "R3";
        OP_READ:  tag = "R2";   // entry 2 also covers R9
        OP_DIRLD: tag = "R4";
        default:  tag = (v[36:34] >= 3'd6) ? "R7" : "R5";
      endcase
      extPull = v[25:20];
      runInstr(v[39:37], v[36:34], v[33:26], 4'b1111);
      check(tag, $sformatf("vec%0d padOut", n), {2'b0, padOut}, {2'b0, v[19:14]});
      check(tag, $sformatf("vec%0d padOe", n), {2'b0, padOe}, {2'b0, v[13:8]});
      check(tag, $sformatf("vec%0d rData", n), rData, v[7:0]);
    end

    // R8: operations outside their phase do nothing
    runInstr(OP_WRITE, 3'd0, 8'h2A, 4'b0111);
    check("R8", "write missing Q4", {2'b0, padOut}, 8'h01);
    runInstr(OP_WRITE, 3'd0, 8'h2A, 4'b1111);
    check("R3", "write full", {2'b0, padOut}, 8'h2A);
    runInstr(OP_READ, 3'd0, 8'h00, 4'b1101);
    check("R8", "read missing Q2", rData, 8'h01);
    runInstr(3'd7, 3'd0, 8'h00, 4'b1111);
    check("R8", "code 7 latch", {2'b0, padOut}, 8'h2A);
    check("R8", "code 7 dir", {2'b0, padOe}, 8'h3F);

    // R9: write then immediate read sees new level
    runInstr(OP_WRITE, 3'd0, 8'h15, 4'b1111);
    runInstr(OP_READ, 3'd0, 8'h00, 4'b1111);
    check("R9", "read after write", rData, 8'h15);

    // R1: reset from a non-default state
    doReset();
    check("R1", "padOe after reset", {2'b0, padOe}, 8'h00);
    check("R1", "padOut after reset", {2'b0, padOut}, 8'h00);
    check("R1", "rData after reset", rData, 8'h00);

    // R6: bit ops overwrite input latches with pin levels
    extPull = 6'h3F;
    runInstr(OP_DIRLD, 3'd0, 8'h38, 4'b1111);
    runInstr(OP_WRITE, 3'd0, 8'h30, 4'b1111);
    runInstr(OP_BCLR, 3'd5, 8'h00, 4'b1111);
    check("R5", "clear bit5", {2'b0, padOut}, 8'h18);
    runInstr(OP_BCLR, 3'd4, 8'h00, 4'b1111);
    check("R6", "bit5 recaptured", {2'b0, padOut}, 8'h28);
    runInstr(OP_DIRLD, 3'd0, 8'h07, 4'b1111);
    check("R6", "dir swapped", {2'b0, padOe}, 8'h38);
    check("R6", "GP5 drives high", {7'b0, padOut[5]}, 8'h01);
    runInstr(OP_READ, 3'd0, 8'h00, 4'b1111);
    check("R6", "pins after swap", rData, 8'h2F);

    finishRun();
  end

endmodule